// File: doc/BRIEF.md
# Indexable Stream Register File Bank

This block is one lane's slice of a stream register file. Its storage is split into four sub-banks, with consecutive words interleaved across them. It serves its compute lane in two ways. A sequential stream port reads or writes one wide block of four consecutive words per cycle. The block address comes from an internal stride-one pointer, which a base value can reload. An indexed port carries several request slots. Each slot holds its own word address, so the lane can do table lookups, reuse data inside a stream and make data-dependent accesses such as sort merges, all within its own bank.

Indexed requests issued in one cycle proceed together when they fall in different sub-banks. Requests that collide on a sub-bank are served over successive cycles, lowest slot first. The bank holds the requester with a stall signal until every slot has been served, and the requester keeps its request inputs unchanged while the stall is high. The sequential port takes every sub-bank for its cycle and has priority over indexed traffic. Read data from either port comes back one cycle after the access, and indexed read data is tagged by request slot.

Top module: `srf_lane_bank`

## Requirements
- R1: After reset, `rd_valid`, `seq_rvalid` and `idx_stall` are low, and the sequential pointer is at block 0, so a first unloaded sequential access uses words 0..3.
- R2: Word address `a` (8 bits, 256 words) is held in sub-bank `a[1:0]` at row `a[7:2]`. Indexed slot `i` (4 slots) uses bits `[8i+7:8i]` of `idx_addr` and `[32i+31:32i]` of `idx_wdata` and `rd_data`.
- R3: An indexed read served in one cycle raises `rd_valid[i]` for its slot in the next cycle, with the addressed word on the slot's field of `rd_data`.
- R4: While `seq_valid` is high, no indexed slot is served, and `idx_stall` is high whenever any indexed slot is still waiting.
- R5: In each cycle every sub-bank serves the lowest-numbered waiting slot that targets it. `idx_stall` is high in every cycle after which a slot is still unserved and low in the final cycle of the batch, so a batch takes as many cycles as the largest number of slots aimed at one sub-bank.
- R6: When two slots of one batch address the same word, the lower slot's access happens first. A write in the lower slot is seen by a read in the higher slot, and a read in the lower slot returns the data from before a write in the higher slot.
- R7: A sequential access uses block `seq_base` when `seq_load` is high and the pointer otherwise. It covers words `4*blk+k`, with lane `k` on bits `[32k+31:32k]` of `seq_wdata`/`seq_rdata`. The pointer then becomes that block plus one, wrapping from 63 to 0.
- R8: A sequential read raises `seq_rvalid` in the next cycle with the whole block on `seq_rdata`.
- R9: Indexed writes and sequential writes produce no `rd_valid` or `seq_rvalid`, and slots whose `idx_valid` bit is low are never served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seq_valid | input | 1 | Sequential block access this cycle |
| seq_we | input | 1 | Sequential access is a write |
| seq_load | input | 1 | Use seq_base instead of the pointer |
| seq_base | input | 6 | Block address to load |
| seq_wdata | input | 128 | Four words to write, lane k at bits 32k |
| seq_rvalid | output | 1 | Sequential read data valid |
| seq_rdata | output | 128 | Sequential read block |
| idx_valid | input | 4 | Per-slot indexed request |
| idx_we | input | 4 | Per-slot write enable |
| idx_addr | input | 32 | Per-slot word address, 8 bits each |
| idx_wdata | input | 128 | Per-slot write data, 32 bits each |
| idx_stall | output | 1 | Batch not finished; hold indexed inputs |
| rd_valid | output | 4 | Per-slot indexed read data valid |
| rd_data | output | 128 | Per-slot indexed read data |

## Verification
Indexed batches are tried with four distinct sub-banks, which must finish in one cycle with no stall. All four slots on one sub-bank must take four cycles, and a mixed pattern with three slots on one sub-bank must take three. Comparing the three tells the per-sub-bank arbitration apart from a global one-at-a-time scheme. Same-word pairs in both slot orders separate lowest-first service from any other order. A batch sent together with a sequential read, and one with sparse valid bits, check the sequential port's priority and that idle slots are skipped. Sequential traffic with and without reload, including the pointer wrap at block 63, also checks through indexed reads that the interleave puts block words on the expected sub-banks.

// File: rtl/srf_pkg.sv
package srf_pkg;
  // what a sub-bank did in the previous cycle, for read-response routing
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_SEQ  = 2'd1,
    SRC_IDX  = 2'd2
  } src_e;
endpackage

// File: rtl/srf_subbank.sv
module srf_subbank #(
  parameter int DATA_W = 32,
  parameter int ROW_W  = 6
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [ROW_W-1:0]  row,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int ROWS = 1 << ROW_W;

  logic [DATA_W-1:0] mem [ROWS];

  // one port: read returns the word as it was before any same-cycle write
  always_ff @(posedge clk) begin
    if (en) begin
      rdata <= mem[row];
      if (we) mem[row] <= wdata;
    end
  end
endmodule

// File: rtl/srf_seq_ctr.sv
module srf_seq_ctr #(
  parameter int BLK_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seq_valid,
  input  logic             seq_load,
  input  logic [BLK_W-1:0] seq_base,
  output logic [BLK_W-1:0] blk
);
  logic [BLK_W-1:0] ptr_q;

  assign blk = seq_load ? seq_base : ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         ptr_q <= '0;
    else if (seq_valid) ptr_q <= blk + 1'b1;
    else if (seq_load)  ptr_q <= seq_base;
  end

  // R7: pointer moves one block past the block just accessed
  a_r7_ptr_advance: assert property (@(posedge clk) disable iff (!rst_n)
    seq_valid |=> (ptr_q == $past(blk) + 1'b1));
endmodule

// File: rtl/srf_arbiter.sv
module srf_arbiter #(
  parameter int NREQ   = 4,
  parameter int NSUB   = 4,
  parameter int SLOT_W = 2,
  parameter int SB_W   = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NREQ-1:0]               active,
  input  logic [NREQ-1:0][SB_W-1:0]     target,
  input  logic                          block,
  output logic [NSUB-1:0]               sb_hit,
  output logic [NSUB-1:0][SLOT_W-1:0]   sb_slot,
  output logic [NREQ-1:0]               grant
);
  for (genvar k = 0; k < NSUB; k++) begin : g_sub
    logic             found;
    logic [SLOT_W-1:0] pick;
    // descending scan so the lowest matching slot is the one left standing
    always_comb begin
      found = 1'b0;
      pick  = '0;
      for (int i = NREQ - 1; i >= 0; i--) begin
        if (active[i] && target[i] == k[SB_W-1:0]) begin
          found = 1'b1;
          pick  = i[SLOT_W-1:0];
        end
      end
    end
    assign sb_hit[k]  = found & ~block;
    assign sb_slot[k] = pick;
  end

  always_comb begin
    grant = '0;
    for (int k = 0; k < NSUB; k++)
      if (sb_hit[k]) grant[sb_slot[k]] = 1'b1;
  end

  // R5: a slot is granted only when it is waiting
  a_r5_grant_active: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~active) == '0);
  // R4: nothing granted while the stream port owns the bank
  a_r4_block_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
    block |-> (grant == '0));
endmodule

// File: rtl/srf_lane_bank.sv
module srf_lane_bank #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int NREQ   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     seq_valid,
  input  logic                     seq_we,
  input  logic                     seq_load,
  input  logic [ADDR_W-3:0]        seq_base,
  input  logic [4*DATA_W-1:0]      seq_wdata,
  output logic                     seq_rvalid,
  output logic [4*DATA_W-1:0]      seq_rdata,
  input  logic [NREQ-1:0]          idx_valid,
  input  logic [NREQ-1:0]          idx_we,
  input  logic [NREQ*ADDR_W-1:0]   idx_addr,
  input  logic [NREQ*DATA_W-1:0]   idx_wdata,
  output logic                     idx_stall,
  output logic [NREQ-1:0]          rd_valid,
  output logic [NREQ*DATA_W-1:0]   rd_data
);
  import srf_pkg::*;

  localparam int NSUB   = 4;
  localparam int SB_W   = 2;
  localparam int ROW_W  = ADDR_W - SB_W;
  localparam int SLOT_W = (NREQ > 1) ? $clog2(NREQ) : 1;

  function automatic logic [SB_W-1:0] sub_of(input logic [ADDR_W-1:0] a);
    return a[SB_W-1:0];
  endfunction

  function automatic logic [ROW_W-1:0] row_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:SB_W];
  endfunction

  // unpack per-slot fields
  logic [ADDR_W-1:0]          slot_addr  [NREQ];
  logic [DATA_W-1:0]          slot_wdata [NREQ];
  logic [NREQ-1:0][SB_W-1:0]  slot_sub;
  for (genvar i = 0; i < NREQ; i++) begin : g_unpack
    assign slot_addr[i]  = idx_addr[i*ADDR_W +: ADDR_W];
    assign slot_wdata[i] = idx_wdata[i*DATA_W +: DATA_W];
    assign slot_sub[i]   = sub_of(slot_addr[i]);
  end

  // batch bookkeeping: slots already served while stalled
  logic [NREQ-1:0] done_q;
  logic [NREQ-1:0] active;
  logic [NREQ-1:0] grant;
  logic [NSUB-1:0] sb_hit;
  logic [NSUB-1:0][SLOT_W-1:0] sb_slot;
  logic [ROW_W-1:0] seq_blk;

  assign active    = idx_valid & ~done_q;
  assign idx_stall = |(active & ~grant);

  always_ff @(posedge clk) begin
    if (!rst_n)         done_q <= '0;
    else if (idx_stall) done_q <= done_q | grant;
    else                done_q <= '0;
  end

  srf_arbiter #(.NREQ(NREQ), .NSUB(NSUB), .SLOT_W(SLOT_W), .SB_W(SB_W)) arb_i (
    .clk(clk), .rst_n(rst_n), .active(active), .target(slot_sub),
    .block(seq_valid), .sb_hit(sb_hit), .sb_slot(sb_slot), .grant(grant)
  );

  srf_seq_ctr #(.BLK_W(ROW_W)) ctr_i (
    .clk(clk), .rst_n(rst_n), .seq_valid(seq_valid), .seq_load(seq_load),
    .seq_base(seq_base), .blk(seq_blk)
  );

  // sub-bank port muxing and response tagging
  logic [DATA_W-1:0] sb_rdata [NSUB];
  src_e              rsp_src  [NSUB];
  logic [SLOT_W-1:0] rsp_slot [NSUB];

  for (genvar k = 0; k < NSUB; k++) begin : g_bank
    logic              en, we;
    logic [ROW_W-1:0]  row;
    logic [DATA_W-1:0] wd;

    always_comb begin
      en  = 1'b0;
      we  = 1'b0;
      row = '0;
      wd  = '0;
      if (seq_valid) begin
        en  = 1'b1;
        we  = seq_we;
        row = seq_blk;
        wd  = seq_wdata[k*DATA_W +: DATA_W];
      end else if (sb_hit[k]) begin
        en  = 1'b1;
        we  = idx_we[sb_slot[k]];
        row = row_of(slot_addr[sb_slot[k]]);
        wd  = slot_wdata[sb_slot[k]];
      end
    end

    srf_subbank #(.DATA_W(DATA_W), .ROW_W(ROW_W)) sb_i (
      .clk(clk), .en(en), .we(we), .row(row), .wdata(wd), .rdata(sb_rdata[k])
    );

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rsp_src[k]  <= SRC_NONE;
        rsp_slot[k] <= '0;
      end else begin
        rsp_slot[k] <= sb_slot[k];
        if (seq_valid && !seq_we)            rsp_src[k] <= SRC_SEQ;
        else if (en && !we && !seq_valid)    rsp_src[k] <= SRC_IDX;
        else                                 rsp_src[k] <= SRC_NONE;
      end
    end

    assign seq_rdata[k*DATA_W +: DATA_W] = sb_rdata[k];
  end

  assign seq_rvalid = (rsp_src[0] == SRC_SEQ);

  always_comb begin
    rd_valid = '0;
    rd_data  = '0;
    for (int k = 0; k < NSUB; k++) begin
      if (rsp_src[k] == SRC_IDX) begin
        rd_valid[rsp_slot[k]] = 1'b1;
        rd_data[rsp_slot[k]*DATA_W +: DATA_W] = sb_rdata[k];
      end
    end
  end

  // R3/R9: an indexed response needs a read request in that slot a cycle earlier
  for (genvar i = 0; i < NREQ; i++) begin : g_chk
    a_r3_rsp_has_req: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid[i] |-> $past(idx_valid[i] && !idx_we[i] && !seq_valid));
  end
  // R8: stream read data only after a stream read
  a_r8_seq_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    seq_rvalid |-> $past(seq_valid && !seq_we));
  // R4: stream and indexed responses never share a cycle
  a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    seq_rvalid |-> (rd_valid == '0));
  // R5: a stalled batch with the bank free serves at least one more slot
  a_r5_progress: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_stall && !seq_valid) |=> ($countones(done_q) > $countones($past(done_q))));
endmodule

// File: tb/srf_lane_bank_tb.sv
`timescale 1ns/1ps
module srf_lane_bank_tb_top;
  localparam int DW = 32;
  localparam int AW = 8;
  localparam int NR = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic seq_valid = 0, seq_we = 0, seq_load = 0;
  logic [5:0] seq_base = '0;
  logic [127:0] seq_wdata = '0;
  logic seq_rvalid;
  logic [127:0] seq_rdata;
  logic [NR-1:0] idx_valid = '0, idx_we = '0;
  logic [NR*AW-1:0] idx_addr = '0;
  logic [NR*DW-1:0] idx_wdata = '0;
  logic idx_stall;
  logic [NR-1:0] rd_valid;
  logic [NR*DW-1:0] rd_data;

  srf_lane_bank #(.DATA_W(DW), .ADDR_W(AW), .NREQ(NR)) dut_i (
    .clk(clk), .rst_n(rst_n), .seq_valid(seq_valid), .seq_we(seq_we),
    .seq_load(seq_load), .seq_base(seq_base), .seq_wdata(seq_wdata),
    .seq_rvalid(seq_rvalid), .seq_rdata(seq_rdata), .idx_valid(idx_valid),
    .idx_we(idx_we), .idx_addr(idx_addr), .idx_wdata(idx_wdata),
    .idx_stall(idx_stall), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  typedef struct {
    bit           is_seq;
    int           slot;
    logic [127:0] data;
    string        req;
  } exp_t;

  exp_t exp_q[$];
  int total = 0, bad = 0;
  bit finished = 0;

  logic [31:0] model [256];
  logic [5:0]  ptr_m = '0;
  logic [31:0] seed = 32'h1357_0000;

  // request description shared by the driver tasks
  logic [NR-1:0] r_v, r_we;
  logic [7:0]    r_a [NR];
  logic [31:0]   r_d [NR];

  function automatic logic [31:0] next_word();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed;
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic drive_idle();
    seq_valid = 0; seq_we = 0; seq_load = 0;
    idx_valid = '0; idx_we = '0;
  endtask

  // one stream access; expected block computed from the model
  task automatic run_seq(input bit ld, input logic [5:0] base, input bit we);
    logic [5:0] blk;
    logic [127:0] blkdata, wd;
    exp_t e;
    @(negedge clk);
    for (int k = 0; k < 4; k++) wd[k*32 +: 32] = next_word();
    seq_valid = 1; seq_we = we; seq_load = ld; seq_base = base; seq_wdata = wd;
    #1;
    blk = ld ? base : ptr_m;
    for (int k = 0; k < 4; k++) blkdata[k*32 +: 32] = model[{blk, 2'(k)}];
    if (we) begin
      for (int k = 0; k < 4; k++) model[{blk, 2'(k)}] = wd[k*32 +: 32];
    end else begin
      e.is_seq = 1; e.slot = -1; e.data = blkdata; e.req = "R7/R8";
      exp_q.push_back(e);
    end
    ptr_m = blk + 6'd1;
    @(negedge clk);
    drive_idle();
  endtask

  // one indexed batch held until done; optionally shares its first cycle with a stream read
  task automatic run_idx(input bit with_seq, input int exp_cycles, input string tag);
    logic [NR-1:0] done_m = '0;
    logic [NR-1:0] act, served;
    bit more = 1;
    bit seq_now;
    int cyc = 0;
    exp_t e;
    for (int i = 0; i < NR; i++) begin
      idx_addr[i*AW +: AW] = r_a[i];
      idx_wdata[i*DW +: DW] = r_d[i];
    end
    while (more && cyc < 10) begin
      @(negedge clk);
      seq_now = with_seq && (cyc == 0);
      idx_valid = r_v; idx_we = r_we;
      seq_valid = seq_now; seq_we = 0; seq_load = 0;
      act = r_v & ~done_m;
      served = '0;
      if (!seq_now) begin
        for (int k = 0; k < 4; k++) begin
          for (int i = 0; i < NR; i++) begin
            if (act[i] && r_a[i][1:0] == 2'(k)) begin
              served[i] = 1;
              break;
            end
          end
        end
      end
      more = |(act & ~served);
      #1;
      check(idx_stall == more, with_seq && cyc == 0 ? "R4 stall" : "R5 stall",
            {127'd0, idx_stall}, {127'd0, more});
      if (seq_now) begin
        e.is_seq = 1; e.slot = -1; e.req = "R4 seq";
        for (int k = 0; k < 4; k++) e.data[k*32 +: 32] = model[{ptr_m, 2'(k)}];
        exp_q.push_back(e);
        ptr_m = ptr_m + 6'd1;
      end
      for (int i = 0; i < NR; i++) begin
        if (served[i] && !r_we[i]) begin
          e.is_seq = 0; e.slot = i; e.req = tag;
          e.data = {96'd0, model[r_a[i]]};
          exp_q.push_back(e);
        end
      end
      for (int i = 0; i < NR; i++)
        if (served[i] && r_we[i]) model[r_a[i]] = r_d[i];
      done_m |= served;
      cyc++;
    end
    check(cyc == exp_cycles, {tag, " batch length"}, 128'(cyc), 128'(exp_cycles));
    @(negedge clk);
    drive_idle();
  endtask

  task automatic set_req(input logic [NR-1:0] v, input logic [NR-1:0] we,
                         input logic [7:0] a0, input logic [7:0] a1,
                         input logic [7:0] a2, input logic [7:0] a3);
    r_v = v; r_we = we;
    r_a[0] = a0; r_a[1] = a1; r_a[2] = a2; r_a[3] = a3;
    for (int i = 0; i < NR; i++) r_d[i] = next_word();
  endtask

  // scoreboard monitor, away from the edge
  always @(posedge clk) begin
    #2;
    if (rst_n && !finished) begin
      if (seq_rvalid) begin
        if (exp_q.size() == 0 || !exp_q[0].is_seq) begin
          check(0, "R8/R9 unexpected seq_rvalid", seq_rdata, '0);
        end else begin
          check(seq_rdata === exp_q[0].data, exp_q[0].req, seq_rdata, exp_q[0].data);
          void'(exp_q.pop_front());
        end
      end
      for (int i = 0; i < NR; i++) begin
        if (rd_valid[i]) begin
          if (exp_q.size() == 0 || exp_q[0].is_seq || exp_q[0].slot != i) begin
            check(0, "R3/R9 unexpected rd_valid", 128'(i), '0);
          end else begin
            check(rd_data[i*DW +: DW] === exp_q[0].data[31:0], exp_q[0].req,
                  {96'd0, rd_data[i*DW +: DW]}, exp_q[0].data);
            void'(exp_q.pop_front());
          end
        end
      end
      if (exp_q.size() != 0) begin
        check(0, {exp_q[0].req, " missing response"}, '0, exp_q[0].data);
        exp_q.delete();
      end
    end
  end

  initial begin
    repeat (30000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(idx_stall == 0 && rd_valid == 0 && seq_rvalid == 0, "R1 reset outputs",
          {122'd0, idx_stall, rd_valid, seq_rvalid}, '0);
    rst_n = 1;
    @(negedge clk);
    check(rd_valid == 0 && seq_rvalid == 0, "R1 idle after reset",
          {123'd0, rd_valid, seq_rvalid}, '0);

    // R1/R7: unloaded writes start at block 0, then block 1
    run_seq(0, 6'd0, 1);
    run_seq(0, 6'd0, 1);
    // R7: loaded then stride-one writes over blocks 4..9
    run_seq(1, 6'd4, 1);
    for (int n = 0; n < 5; n++) run_seq(0, 6'd0, 1);

    // R2/R3/R7: block 0 words across four sub-banks, no conflict
    set_req(4'b1111, 4'b0000, 8'h02, 8'h00, 8'h03, 8'h01);
    run_idx(0, 1, "R2/R3 spread read");

    // R7/R8: stream reads, reload then increment
    run_seq(1, 6'd0, 0);
    run_seq(0, 6'd0, 0);
    run_seq(1, 6'd7, 0);

    // R9: indexed writes, one per sub-bank
    set_req(4'b1111, 4'b1111, 8'h10, 8'h21, 8'h32, 8'h43);
    run_idx(0, 1, "R9 write");
    set_req(4'b1111, 4'b0000, 8'h43, 8'h32, 8'h21, 8'h10);
    run_idx(0, 1, "R9 readback");

    // R5: all slots on sub-bank 0
    set_req(4'b1111, 4'b1111, 8'h14, 8'h18, 8'h1C, 8'h20);
    run_idx(0, 4, "R5 full conflict write");
    set_req(4'b1111, 4'b0000, 8'h20, 8'h1C, 8'h18, 8'h14);
    run_idx(0, 4, "R5 full conflict read");

    // R5: three slots on sub-bank 1, one on sub-bank 2
    set_req(4'b1111, 4'b0000, 8'h11, 8'h15, 8'h12, 8'h19);
    run_idx(0, 3, "R5 partial conflict");

    // R6: lower write then higher read of the same word
    set_req(4'b0011, 4'b0001, 8'h24, 8'h24, 8'h00, 8'h00);
    run_idx(0, 2, "R6 write-then-read");
    // R6: lower read then higher write
    set_req(4'b0011, 4'b0010, 8'h24, 8'h24, 8'h00, 8'h00);
    run_idx(0, 2, "R6 read-then-write");
    set_req(4'b0001, 4'b0000, 8'h24, 8'h00, 8'h00, 8'h00);
    run_idx(0, 1, "R6 final value");

    // R4: stream read shares the first cycle with a batch
    set_req(4'b1111, 4'b0000, 8'h13, 8'h16, 8'h25, 8'h04);
    run_seq(1, 6'd4, 0);
    run_idx(1, 2, "R4 after stream");

    // R9: sparse valid bits; idle slots aim at sub-bank 0 and must not be served
    set_req(4'b0101, 4'b0000, 8'h17, 8'h10, 8'h22, 8'h14);
    run_idx(0, 1, "R9 sparse");

    // R7: pointer wrap from block 63 to 0
    run_seq(1, 6'd63, 1);
    run_seq(0, 6'd0, 1);
    run_seq(1, 6'd63, 0);
    run_seq(0, 6'd0, 0);

    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule